// File: doc/BRIEF.md
# Masked Register Save/Restore Sequencer

This block moves any chosen subset of seven word-wide scratch registers to or from a stack in memory that grows downward. One command byte sets both the direction of the transfer and the set of registers that take part. The engine then walks the chosen registers in a fixed order and issues one memory access per register. It keeps the stack pointer current as it goes and pulses `done_o` when every output shows the finished result.

The order of the walk reverses with the direction. A save starts at the highest selected index and a restore starts at the lowest. Because of this, a restore does not need the same mask as the save that came before it. Stacked values can land in other registers, which lets the block shuffle register contents through the stack.

A host loads the registers and the stack pointer through simple write ports while the engine is idle. The registers and the stack pointer are always visible on outputs. The memory port is synchronous: read data arrives one cycle after the request.

Top module: `regsave_seq`

## Requirements
- R1: After reset, `cmd_ready_o` is 1, `done_o` is 0, `mem_en_o` is 0, the stack pointer is 0 and all seven registers read 0.
- R2: Command bit 7 chooses the direction (1 = restore from stack, 0 = save to stack). Bit k (k = 0..6) selects register k. For example, 0x05 saves only registers 2 and 0.
- R3: A save visits the selected registers from the highest index to the lowest. For each one it writes the register value at address SP-2 with `mem_we_o`=1, and SP drops by 2.
- R4: A restore visits the selected registers from the lowest index to the highest. For each one it reads at address SP with `mem_we_o`=0, SP rises by 2, and the word returned one cycle later is loaded into that register.
- R5: Each selected register costs exactly one memory cycle, in back-to-back cycles starting the cycle after acceptance. Registers that are not selected keep their values.
- R6: A command whose bits 6..0 are all zero raises `done_o` in the cycle after acceptance, makes no memory access and leaves SP unchanged.
- R7: `cmd_ready_o` is low from the cycle after acceptance until the `done_o` cycle. A `cmd_valid_i` presented while it is low is ignored.
- R8: `done_o` is a one-cycle pulse. For a save it comes in the cycle after the last write. For a restore it comes two cycles after the last read request, and the restored registers already hold their new values in that cycle.
- R9: Host writes to a register or to SP take effect only while `cmd_ready_o` is high. While a command is running they are ignored.
- R10: Saving with mask {5,2} and then restoring with mask {1,2} leaves register 1 holding the old register 2 and register 2 holding the old register 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine idle, command accepted when valid |
| cmd_byte_i | input | 8 | Bit 7 direction, bits 6..0 register select |
| done_o | output | 1 | Completion pulse |
| reg_wr_en_i | input | 1 | Host register write strobe |
| reg_wr_idx_i | input | 3 | Host register write index |
| reg_wr_data_i | input | 16 | Host register write data |
| sp_wr_en_i | input | 1 | Host stack pointer write strobe |
| sp_wr_data_i | input | 16 | Host stack pointer write value |
| sp_o | output | 16 | Current stack pointer |
| regs_o | output | 112 | Register k at bits 16k+15..16k |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 16 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, one cycle after a read request |

## Verification
A command accepted at one clock edge issues its first memory access in the next cycle and then one access per selected register. For n selected registers, `done_o` is therefore due n+1 cycles after acceptance for a save and n+2 for a restore; an empty mask gives `done_o` after exactly one cycle. The bench counts falling edges from acceptance and compares that count with these figures. It checks the access log, the registers and SP only at the falling edge of the `done_o` cycle, when every update has already landed.

// File: rtl/regsave_pkg.sv
package regsave_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/regsave_pick.sv
module regsave_pick #(
  parameter int N_REGS = 7,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic [N_REGS-1:0] mask_i,
  input  logic              pop_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  // restore: lowest set index wins; save: highest set index wins
  always_comb begin
    idx_o = '0;
    any_o = |mask_i;
    if (pop_i) begin
      for (int i = N_REGS - 1; i >= 0; i--) begin
        if (mask_i[i]) idx_o = IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < N_REGS; i++) begin
        if (mask_i[i]) idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/regsave_bank.sv
module regsave_bank #(
  parameter int N_REGS = 7,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     host_en_i,
  input  logic [IDX_W-1:0]         host_idx_i,
  input  logic [DATA_W-1:0]        host_data_i,
  input  logic                     wb_en_i,
  input  logic [IDX_W-1:0]         wb_idx_i,
  input  logic [DATA_W-1:0]        wb_data_i,
  output logic [N_REGS*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    logic              en_g;
    logic [DATA_W-1:0] d_g;
    logic [DATA_W-1:0] q_g;

    always_comb begin
      en_g = (wb_en_i && (wb_idx_i == IDX_W'(g))) ||
             (host_en_i && (host_idx_i == IDX_W'(g)));
      d_g  = wb_en_i ? wb_data_i : host_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_g <= '0;
      end else if (en_g) begin
        q_g <= d_g;
      end
    end

    assign regs_o[g*DATA_W +: DATA_W] = q_g;
  end
endmodule

// File: rtl/regsave_ctrl.sv
module regsave_ctrl
  import regsave_pkg::*;
#(
  parameter int N_REGS = 7,
  parameter int ADDR_W = 16,
  parameter int WORD_BYTES = 2,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic [N_REGS:0]   cmd_byte_i,
  output logic              cmd_ready_o,
  input  logic              sp_wr_en_i,
  input  logic [ADDR_W-1:0] sp_wr_data_i,
  output logic [N_REGS-1:0] mask_o,
  output logic              pop_o,
  input  logic [IDX_W-1:0]  pick_idx_i,
  input  logic              pick_any_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [N_REGS-1:0] ONE  = N_REGS'(1);

  seq_state_e        state_q, state_d;
  logic [N_REGS-1:0] mask_q, mask_d;
  logic              pop_q, pop_d;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              sp_en;
  logic              done_q, done_d;
  logic              wb_q, wb_d;
  logic [IDX_W-1:0]  wbidx_q, wbidx_d;

  always_comb begin
    state_d    = state_q;
    mask_d     = mask_q;
    pop_d      = pop_q;
    sp_d       = sp_q;
    sp_en      = 1'b0;
    done_d     = 1'b0;
    wb_d       = 1'b0;
    wbidx_d    = wbidx_q;
    mem_en_o   = 1'b0;
    mem_we_o   = 1'b0;
    mem_addr_o = sp_q;
    cmd_ready_o = (state_q == ST_IDLE);
    case (state_q)
      ST_IDLE: begin
        if (sp_wr_en_i) begin
          sp_d  = sp_wr_data_i;
          sp_en = 1'b1;
        end
        if (cmd_valid_i) begin
          pop_d  = cmd_byte_i[N_REGS];
          mask_d = cmd_byte_i[N_REGS-1:0];
          if (cmd_byte_i[N_REGS-1:0] == '0) done_d  = 1'b1;
          else                              state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        mem_en_o   = pick_any_i;
        mem_we_o   = !pop_q;
        mem_addr_o = pop_q ? sp_q : sp_q - STEP;
        sp_d       = pop_q ? sp_q + STEP : sp_q - STEP;
        sp_en      = pick_any_i;
        mask_d     = mask_q & ~(ONE << pick_idx_i);
        if (pop_q) begin
          wb_d    = pick_any_i;
          wbidx_d = pick_idx_i;
        end
        if (mask_d == '0) begin
          if (pop_q) begin
            state_d = ST_WAIT;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      pop_q   <= 1'b0;
      sp_q    <= '0;
      done_q  <= 1'b0;
      wb_q    <= 1'b0;
      wbidx_q <= '0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      pop_q   <= pop_d;
      done_q  <= done_d;
      wb_q    <= wb_d;
      wbidx_q <= wbidx_d;
      if (sp_en) sp_q <= sp_d;
    end
  end

  assign mask_o   = mask_q;
  assign pop_o    = pop_q;
  assign wb_en_o  = wb_q;
  assign wb_idx_o = wbidx_q;
  assign done_o   = done_q;
  assign sp_o     = sp_q;

  a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o && cmd_byte_i[N_REGS-1:0] == '0) |=> (done_o && !mem_en_o));

  a_r3_save_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && mem_we_o) |=> (sp_o == ADDR_W'($past(sp_o) - STEP)));

  a_r4_restore_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |=> (sp_o == ADDR_W'($past(sp_o) + STEP)));

  a_r4_restore_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o) |=> wb_en_o);

  a_r7_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> !mem_en_o);

  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cmd_ready_o && !mem_en_o));
endmodule

// File: rtl/regsave_seq.sv
module regsave_seq #(
  parameter int N_REGS = 7,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid_i,
  output logic                     cmd_ready_o,
  input  logic [N_REGS:0]          cmd_byte_i,
  output logic                     done_o,
  input  logic                     reg_wr_en_i,
  input  logic [IDX_W-1:0]         reg_wr_idx_i,
  input  logic [DATA_W-1:0]        reg_wr_data_i,
  input  logic                     sp_wr_en_i,
  input  logic [ADDR_W-1:0]        sp_wr_data_i,
  output logic [ADDR_W-1:0]        sp_o,
  output logic [N_REGS*DATA_W-1:0] regs_o,
  output logic                     mem_en_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  input  logic [DATA_W-1:0]        mem_rdata_i
);
  logic [N_REGS-1:0] mask;
  logic              pop;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic              wb_en;
  logic [IDX_W-1:0]  wb_idx;

  regsave_pick #(.N_REGS(N_REGS)) u_pick (
    .mask_i (mask),
    .pop_i  (pop),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  regsave_ctrl #(.N_REGS(N_REGS), .ADDR_W(ADDR_W), .WORD_BYTES(DATA_W / 8)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_byte_i   (cmd_byte_i),
    .cmd_ready_o  (cmd_ready_o),
    .sp_wr_en_i   (sp_wr_en_i),
    .sp_wr_data_i (sp_wr_data_i),
    .mask_o       (mask),
    .pop_o        (pop),
    .pick_idx_i   (pick_idx),
    .pick_any_i   (pick_any),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .wb_en_o      (wb_en),
    .wb_idx_o     (wb_idx),
    .done_o       (done_o),
    .sp_o         (sp_o)
  );

  regsave_bank #(.N_REGS(N_REGS), .DATA_W(DATA_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_en_i   (reg_wr_en_i && cmd_ready_o),
    .host_idx_i  (reg_wr_idx_i),
    .host_data_i (reg_wr_data_i),
    .wb_en_i     (wb_en),
    .wb_idx_i    (wb_idx),
    .wb_data_i   (mem_rdata_i),
    .regs_o      (regs_o)
  );

  // store data: value of the register the picker points at
  always_comb begin
    mem_wdata_o = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (pick_idx == IDX_W'(i)) mem_wdata_o = regs_o[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: tb/regsave_seq_test.sv
`timescale 1ns/1ps
module regsave_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_byte = '0;
  logic        done;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_idx = '0;
  logic [15:0] reg_wr_data = '0;
  logic        sp_wr_en = 1'b0;
  logic [15:0] sp_wr_data = '0;
  logic [15:0] sp;
  logic [111:0] regs;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  int n_acc = 0;
  int cyc_total = 0;
  logic [15:0] log_addr [0:15];
  logic [15:0] log_data [0:15];
  logic        log_we   [0:15];
  logic [15:0] mem [0:255];

  always #2.5 clk = ~clk;

  regsave_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_byte_i(cmd_byte), .done_o(done), .reg_wr_en_i(reg_wr_en),
    .reg_wr_idx_i(reg_wr_idx), .reg_wr_data_i(reg_wr_data), .sp_wr_en_i(sp_wr_en),
    .sp_wr_data_i(sp_wr_data), .sp_o(sp), .regs_o(regs), .mem_en_o(mem_en),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[8:1]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[8:1]];
      if (n_acc < 16) begin
        log_addr[n_acc] <= mem_addr;
        log_data[n_acc] <= mem_we ? mem_wdata : mem[mem_addr[8:1]];
        log_we[n_acc]   <= mem_we;
      end
      n_acc <= n_acc + 1;
    end
  end

  function automatic logic [15:0] rv(input int i);
    return regs[i*16 +: 16];
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_reg(input int i, input logic [15:0] v);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_idx = 3'(i); reg_wr_data = v;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic set_sp(input logic [15:0] v);
    @(negedge clk);
    sp_wr_en = 1'b1; sp_wr_data = v;
    @(negedge clk);
    sp_wr_en = 1'b0;
  endtask

  // returns cycles from acceptance edge to the done cycle
  task automatic run_cmd(input logic [7:0] c, output int cyc);
    @(negedge clk);
    n_acc = 0;
    cmd_valid = 1'b1; cmd_byte = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset;
    check("R1", "ready", 32'(cmd_ready), 32'd1);
    check("R1", "done", 32'(done), 32'd0);
    check("R1", "mem_en", 32'(mem_en), 32'd0);
    check("R1", "sp", 32'(sp), 32'd0);
    for (int i = 0; i < 7; i++) check("R1", "reg", 32'(rv(i)), 32'd0);
  endtask

  task automatic load_pattern;
    for (int i = 0; i < 7; i++) set_reg(i, 16'h1000 * 16'(i + 1) + 16'h00A5);
  endtask

  task automatic t_push_05;
    int cyc;
    load_pattern();
    set_sp(16'h0100);
    run_cmd(8'h05, cyc);
    check("R8", "push cycles", 32'(cyc), 32'd3);
    check("R5", "accesses", 32'(n_acc), 32'd2);
    check("R3", "1st addr", 32'(log_addr[0]), 32'h00FE);
    check("R2", "1st data R2", 32'(log_data[0]), 32'h30A5);
    check("R3", "1st we", 32'(log_we[0]), 32'd1);
    check("R3", "2nd addr", 32'(log_addr[1]), 32'h00FC);
    check("R2", "2nd data R0", 32'(log_data[1]), 32'h10A5);
    check("R3", "sp", 32'(sp), 32'h00FC);
  endtask

  task automatic t_push_all_pop_all;
    int cyc;
    set_sp(16'h0100);
    run_cmd(8'h7F, cyc);
    check("R8", "push all cycles", 32'(cyc), 32'd8);
    check("R5", "push all accesses", 32'(n_acc), 32'd7);
    for (int k = 0; k < 7; k++) begin
      check("R3", "push order addr", 32'(log_addr[k]), 32'(16'h00FE - 16'(2 * k)));
      check("R3", "push order data", 32'(log_data[k]), 32'(16'h1000 * 16'(7 - k) + 16'h00A5));
    end
    check("R3", "sp after push", 32'(sp), 32'h00F2);
    for (int i = 0; i < 7; i++) set_reg(i, 16'hBEEF);
    run_cmd(8'hFF, cyc);
    check("R8", "pop all cycles", 32'(cyc), 32'd9);
    check("R5", "pop all accesses", 32'(n_acc), 32'd7);
    for (int k = 0; k < 7; k++) begin
      check("R4", "pop order addr", 32'(log_addr[k]), 32'(16'h00F2 + 16'(2 * k)));
      check("R4", "pop we", 32'(log_we[k]), 32'd0);
    end
    for (int i = 0; i < 7; i++)
      check("R4", "restored", 32'(rv(i)), 32'(16'h1000 * 16'(i + 1) + 16'h00A5));
    check("R4", "sp after pop", 32'(sp), 32'h0100);
  endtask

  task automatic t_partial_pop;
    int cyc;
    load_pattern();
    set_sp(16'h0080);
    run_cmd(8'h7F, cyc);
    set_reg(3, 16'h5555);
    set_reg(4, 16'h6666);
    run_cmd(8'h88, cyc);
    check("R8", "pop one cycles", 32'(cyc), 32'd3);
    check("R4", "R3 gets lowest slot", 32'(rv(3)), 32'h10A5);
    check("R5", "R4 untouched", 32'(rv(4)), 32'h6666);
    check("R5", "R6 untouched", 32'(rv(6)), 32'h70A5);
    check("R4", "sp", 32'(sp), 32'h0074);
  endtask

  task automatic t_empty;
    int cyc;
    set_sp(16'h0040);
    run_cmd(8'h00, cyc);
    check("R6", "empty push cycles", 32'(cyc), 32'd1);
    check("R6", "empty push accesses", 32'(n_acc), 32'd0);
    run_cmd(8'h80, cyc);
    check("R6", "empty pop cycles", 32'(cyc), 32'd1);
    check("R6", "empty pop accesses", 32'(n_acc), 32'd0);
    check("R6", "sp", 32'(sp), 32'h0040);
  endtask

  task automatic t_busy;
    int cyc;
    int low_seen;
    logic [15:0] r3;
    load_pattern();
    r3 = rv(3);
    set_sp(16'h0100);
    @(negedge clk);
    n_acc = 0;
    cmd_valid = 1'b1; cmd_byte = 8'h7F;
    @(negedge clk);
    cyc = 1; low_seen = 0;
    cmd_byte = 8'h81;
    reg_wr_en = 1'b1; reg_wr_idx = 3'd3; reg_wr_data = 16'hDEAD;
    sp_wr_en = 1'b1; sp_wr_data = 16'h0010;
    while (!done && cyc < 40) begin
      if (cmd_ready == 1'b0) low_seen++;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0; reg_wr_en = 1'b0; sp_wr_en = 1'b0;
    check("R7", "ready low cycles", 32'(low_seen), 32'd7);
    check("R7", "done cycle", 32'(cyc), 32'd8);
    check("R7", "accesses", 32'(n_acc), 32'd7);
    check("R9", "reg write ignored", 32'(rv(3)), 32'(r3));
    check("R9", "sp write ignored", 32'(sp), 32'h00F2);
    @(negedge clk);
    check("R8", "done one pulse", 32'(done), 32'd0);
  endtask

  task automatic t_cross;
    int cyc;
    set_sp(16'h0100);
    set_reg(5, 16'hAAAA);
    set_reg(2, 16'hBBBB);
    set_reg(1, 16'hCCCC);
    run_cmd(8'h24, cyc);
    run_cmd(8'h86, cyc);
    check("R10", "R1 holds old R2", 32'(rv(1)), 32'hBBBB);
    check("R10", "R2 holds old R5", 32'(rv(2)), 32'hAAAA);
    check("R10", "sp", 32'(sp), 32'h0100);
  endtask

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total == 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_05();
    t_push_all_pop_all();
    t_partial_pop();
    t_empty();
    t_busy();
    t_cross();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule